// File: doc/BRIEF.md
# AUX Request Frame Builder

This block turns one DisplayPort AUX request into the byte sequence a line serializer sends on the wire. A request is a 4-bit command, a 20-bit address, a length from 0 to a parameterised maximum (16 by default), and, for write commands, that many payload bytes on a flat data bus. It is accepted with a valid/ready handshake. When the request is accepted, the block captures every field, so the requester can move on.

Before it loads the new frame, the block pulses an acknowledge to the serializer's done flag. It then waits a bounded number of cycles for that flag to fall. Next it streams the header, the optional length byte and any payload bytes over a byte-wide valid/ready interface. One cycle after the last byte it issues a single go pulse, and it stays busy until the serializer raises done again. The sink may hold `tx_ready` low for any number of cycles. While it does, the offered byte and `tx_valid` stay unchanged. `req_ready` is high only when the block is idle, so a requester that holds `req_valid` waits without losing its request.

Top module: `aux_req_framer`

## Requirements
- R1: Byte 0 of the frame is {command[3:0], address[19:16]}, byte 1 is address[15:8], byte 2 is address[7:0].
- R2: When the request length L is non-zero, byte 3 is L-1 (zero-extended). When L is 0, no length byte is sent.
- R3: `byte_cnt` equals 3 when L is 0 and 4 otherwise, plus L when the command carries payload. It is valid from the cycle after acceptance until the block returns to idle.
- R4: Payload bytes follow in index order (byte i from `req_data[8i+7:8i]`). They are sent only for command codes 4'b1000 (native write), 4'b0000 (I2C write) and 4'b0100 (I2C write, middle-of-transaction). Every other code, including the status-request codes 4'b0010 and 4'b0110, sends no payload.
- R5: Exactly `byte_cnt` bytes are offered. While `tx_valid` is high and `tx_ready` is low, `tx_valid` stays high and `tx_data` holds its value.
- R6: `tx_go` is high for exactly one cycle, the cycle after the handshake of the last byte.
- R7: `done_ack` is high for one cycle, in the cycle after a valid request is accepted. No byte is offered while `ser_done` is still high after that acknowledge.
- R8: If `ser_done` stays high for POLL_LIMIT consecutive cycles after the acknowledge, the request is dropped. `req_err` pulses with `req_err_code` = 2, exactly POLL_LIMIT+1 cycles after the `done_ack` cycle, and no byte is sent.
- R9: A request with length above MAX_LEN is rejected. `req_err` pulses with code 1 in the cycle after acceptance, and there is no acknowledge, no byte, no go and no busy.
- R10: `req_ready` is high only while not busy. After `tx_go`, `busy` stays high until `ser_done` is seen high, and it falls in the following cycle.
- R11: After reset, `req_ready` is 1 and `busy`, `tx_valid`, `tx_go`, `done_ack` and `req_err` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block idle, request taken this cycle if valid |
| req_cmd | input | 4 | AUX command nibble |
| req_addr | input | 20 | Target address |
| req_len | input | 5 | Request length in bytes |
| req_data | input | 128 | Write payload, byte i in bits 8i+7:8i |
| req_err | output | 1 | One-cycle error pulse |
| req_err_code | output | 2 | Last error: 1 length, 2 done stuck |
| busy | output | 1 | Request in progress |
| byte_cnt | output | 5 | Total bytes of the current frame |
| tx_valid | output | 1 | Frame byte offered |
| tx_ready | input | 1 | Serializer takes the byte |
| tx_data | output | 8 | Frame byte |
| tx_go | output | 1 | Start pulse to the serializer |
| ser_done | input | 1 | Serializer done flag |
| done_ack | output | 1 | Acknowledge pulse for the done flag |

## Verification
The bench targets four corner cases. The first is length 0, where a design that always adds the length byte would send 4 bytes instead of 3. The second is the status-request codes, where a design that keys payload on a "write" bit would append data. The third is length exactly MAX_LEN against MAX_LEN+1, where an off-by-one compare either rejects a legal request or streams past the payload store. The fourth is `ser_done` falling in the very last poll cycle against one cycle later, where a wrong bound would time out early or stream late. Random sink stalls expose a byte that changes under back-pressure, and a go pulse counted from the wrong handshake lands one cycle off.

// File: rtl/aux_frm_pkg.sv
package aux_frm_pkg;

  localparam int CMD_W  = 4;
  localparam int ADDR_W = 20;
  localparam int BYTE_W = 8;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ACK,
    ST_POLL,
    ST_SEND,
    ST_GO,
    ST_RUN
  } frm_state_t;

  typedef enum logic [1:0] {
    ERR_NONE  = 2'd0,
    ERR_LEN   = 2'd1,
    ERR_STUCK = 2'd2
  } frm_err_t;

  // Commands that carry a data phase: native write, I2C write, I2C write with MOT.
  function automatic logic cmd_has_payload(input logic [CMD_W-1:0] cmd);
    return (cmd == 4'b1000) || (cmd == 4'b0000) || (cmd == 4'b0100);
  endfunction

endpackage

// File: rtl/aux_frm_store.sv
module aux_frm_store #(
  parameter int MAX_LEN = 16,
  parameter int LEN_W   = $clog2(MAX_LEN + 1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 load,
  input  logic [MAX_LEN*8-1:0] data_flat,
  input  logic [LEN_W-1:0]     rd_idx,
  output logic [7:0]           rd_byte
);

  logic [7:0] slot [MAX_LEN];

  for (genvar g = 0; g < MAX_LEN; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        slot[g] <= '0;
      end else if (load) begin
        slot[g] <= data_flat[g*8 +: 8];
      end
    end
  end

  always_comb begin
    rd_byte = '0;
    for (int i = 0; i < MAX_LEN; i++) begin
      if (rd_idx == LEN_W'(i)) begin
        rd_byte = slot[i];
      end
    end
  end

endmodule

// File: rtl/aux_frm_hdr.sv
module aux_frm_hdr
  import aux_frm_pkg::*;
#(
  parameter int MAX_LEN = 16,
  parameter int LEN_W   = $clog2(MAX_LEN + 1),
  parameter int CNT_W   = $clog2(MAX_LEN + 5)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [CMD_W-1:0]  cmd,
  input  logic [ADDR_W-1:0] addr,
  input  logic [LEN_W-1:0]  len,
  input  logic [CNT_W-1:0]  idx,
  input  logic [7:0]        pl_byte,
  output logic [LEN_W-1:0]  pl_idx,
  output logic [7:0]        cur_byte,
  output logic [CNT_W-1:0]  total
);

  logic [CMD_W-1:0]  cmd_q;
  logic [ADDR_W-1:0] addr_q;
  logic [LEN_W-1:0]  len_q;
  logic              pl_q;
  logic              len_nz;
  logic [LEN_W-1:0]  len_m1;
  logic [CNT_W-1:0]  head_n;
  logic [CNT_W-1:0]  off;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmd_q  <= '0;
      addr_q <= '0;
      len_q  <= '0;
      pl_q   <= 1'b0;
    end else if (load) begin
      cmd_q  <= cmd;
      addr_q <= addr;
      len_q  <= len;
      pl_q   <= cmd_has_payload(cmd);
    end
  end

  assign len_nz = (len_q != '0);
  assign len_m1 = len_q - LEN_W'(1);
  assign head_n = len_nz ? CNT_W'(4) : CNT_W'(3);
  assign total  = head_n + (pl_q ? CNT_W'(len_q) : '0);

  // Payload position once the 4-byte header (with length) is past.
  assign off    = idx - CNT_W'(4);
  assign pl_idx = off[LEN_W-1:0];

  always_comb begin
    unique case (idx)
      CNT_W'(0): cur_byte = {cmd_q, addr_q[19:16]};
      CNT_W'(1): cur_byte = addr_q[15:8];
      CNT_W'(2): cur_byte = addr_q[7:0];
      CNT_W'(3): cur_byte = len_nz ? 8'(len_m1) : pl_byte;
      default:   cur_byte = pl_byte;
    endcase
  end

endmodule

// File: rtl/aux_frm_ctrl.sv
module aux_frm_ctrl
  import aux_frm_pkg::*;
#(
  parameter int MAX_LEN    = 16,
  parameter int POLL_LIMIT = 64,
  parameter int LEN_W      = $clog2(MAX_LEN + 1),
  parameter int CNT_W      = $clog2(MAX_LEN + 5)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic [LEN_W-1:0] req_len,
  input  logic             ser_done,
  input  logic             tx_ready,
  input  logic [CNT_W-1:0] total,
  output logic             req_ready,
  output logic             load,
  output logic             done_ack,
  output logic             tx_valid,
  output logic [CNT_W-1:0] idx,
  output logic             go,
  output logic             busy,
  output logic             err,
  output logic [1:0]       err_code
);

  localparam int POLL_W = $clog2(POLL_LIMIT + 1);

  frm_state_t        state;
  logic [POLL_W-1:0] poll;
  logic              len_bad;
  frm_err_t          code_q;

  assign len_bad   = (req_len > LEN_W'(MAX_LEN));
  assign req_ready = (state == ST_IDLE);
  assign load      = req_valid && req_ready && !len_bad;
  assign done_ack  = (state == ST_ACK);
  assign tx_valid  = (state == ST_SEND);
  assign go        = (state == ST_GO);
  assign busy      = (state != ST_IDLE);
  assign err_code  = code_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      idx    <= '0;
      poll   <= '0;
      err    <= 1'b0;
      code_q <= ERR_NONE;
    end else begin
      err <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (req_valid) begin
            if (len_bad) begin
              err    <= 1'b1;
              code_q <= ERR_LEN;
            end else begin
              state <= ST_ACK;
            end
          end
        end
        ST_ACK: begin
          state <= ST_POLL;
          poll  <= '0;
        end
        ST_POLL: begin
          if (!ser_done) begin
            state <= ST_SEND;
            idx   <= '0;
          end else if (poll == POLL_W'(POLL_LIMIT - 1)) begin
            state  <= ST_IDLE;
            err    <= 1'b1;
            code_q <= ERR_STUCK;
          end else begin
            poll <= poll + POLL_W'(1);
          end
        end
        ST_SEND: begin
          if (tx_ready) begin
            if (idx == total - CNT_W'(1)) begin
              state <= ST_GO;
            end else begin
              idx <= idx + CNT_W'(1);
            end
          end
        end
        ST_GO: state <= ST_RUN;
        ST_RUN: begin
          if (ser_done) begin
            state <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/aux_req_framer.sv
module aux_req_framer
  import aux_frm_pkg::*;
#(
  parameter int MAX_LEN    = 16,
  parameter int POLL_LIMIT = 64,
  parameter int LEN_W      = $clog2(MAX_LEN + 1),
  parameter int CNT_W      = $clog2(MAX_LEN + 5)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req_valid,
  output logic                 req_ready,
  input  logic [3:0]           req_cmd,
  input  logic [19:0]          req_addr,
  input  logic [LEN_W-1:0]     req_len,
  input  logic [MAX_LEN*8-1:0] req_data,
  output logic                 req_err,
  output logic [1:0]           req_err_code,
  output logic                 busy,
  output logic [CNT_W-1:0]     byte_cnt,
  output logic                 tx_valid,
  input  logic                 tx_ready,
  output logic [7:0]           tx_data,
  output logic                 tx_go,
  input  logic                 ser_done,
  output logic                 done_ack
);

  logic             load;
  logic [CNT_W-1:0] idx;
  logic [LEN_W-1:0] pl_idx;
  logic [7:0]       pl_byte;

  aux_frm_ctrl #(
    .MAX_LEN(MAX_LEN), .POLL_LIMIT(POLL_LIMIT), .LEN_W(LEN_W), .CNT_W(CNT_W)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_len(req_len),
    .ser_done(ser_done), .tx_ready(tx_ready), .total(byte_cnt),
    .req_ready(req_ready), .load(load), .done_ack(done_ack),
    .tx_valid(tx_valid), .idx(idx), .go(tx_go), .busy(busy),
    .err(req_err), .err_code(req_err_code)
  );

  aux_frm_hdr #(
    .MAX_LEN(MAX_LEN), .LEN_W(LEN_W), .CNT_W(CNT_W)
  ) u_hdr (
    .clk(clk), .rst_n(rst_n), .load(load), .cmd(req_cmd), .addr(req_addr),
    .len(req_len), .idx(idx), .pl_byte(pl_byte), .pl_idx(pl_idx),
    .cur_byte(tx_data), .total(byte_cnt)
  );

  aux_frm_store #(
    .MAX_LEN(MAX_LEN), .LEN_W(LEN_W)
  ) u_store (
    .clk(clk), .rst_n(rst_n), .load(load), .data_flat(req_data),
    .rd_idx(pl_idx), .rd_byte(pl_byte)
  );

endmodule

// File: rtl/aux_frm_chk.sv
module aux_frm_chk #(
  parameter int MAX_LEN = 16,
  parameter int LEN_W   = $clog2(MAX_LEN + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic             req_ready,
  input logic [LEN_W-1:0] req_len,
  input logic             req_err,
  input logic             busy,
  input logic             tx_valid,
  input logic             tx_ready,
  input logic [7:0]       tx_data,
  input logic             tx_go,
  input logic             ser_done,
  input logic             done_ack
);

  a_r5_hold_byte: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && !tx_ready |=> tx_valid && $stable(tx_data));

  a_r6_go_single: assert property (@(posedge clk) disable iff (!rst_n)
    tx_go |=> !tx_go);

  a_r6_go_after_last: assert property (@(posedge clk) disable iff (!rst_n)
    tx_go |-> $past(tx_valid && tx_ready));

  a_r7_ack_on_accept: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready && (req_len <= LEN_W'(MAX_LEN)) |=> done_ack);

  a_r7_send_after_drop: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_valid) |-> !$past(ser_done));

  a_r9_reject_len: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready && (req_len > LEN_W'(MAX_LEN)) |=> req_err && !busy && !done_ack);

  a_r10_busy_after_go: assert property (@(posedge clk) disable iff (!rst_n)
    tx_go |=> busy && !req_ready);

endmodule

bind aux_req_framer aux_frm_chk #(.MAX_LEN(MAX_LEN), .LEN_W(LEN_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_len(req_len), .req_err(req_err), .busy(busy), .tx_valid(tx_valid),
  .tx_ready(tx_ready), .tx_data(tx_data), .tx_go(tx_go), .ser_done(ser_done),
  .done_ack(done_ack)
);

// File: tb/sim_aux_req_framer.sv
`timescale 1ns/1ps
module sim_aux_req_framer;

  localparam int MAXL = 16;
  localparam int PL   = 64;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         req_valid = 1'b0;
  logic         req_ready;
  logic [3:0]   req_cmd = '0;
  logic [19:0]  req_addr = '0;
  logic [4:0]   req_len = '0;
  logic [127:0] req_data = '0;
  logic         req_err;
  logic [1:0]   req_err_code;
  logic         busy;
  logic [4:0]   byte_cnt;
  logic         tx_valid;
  logic         tx_ready = 1'b0;
  logic [7:0]   tx_data;
  logic         tx_go;
  logic         ser_done = 1'b1;
  logic         done_ack;

  int tests = 0;
  int fails = 0;

  always #4 clk = ~clk;

  aux_req_framer #(.MAX_LEN(MAXL), .POLL_LIMIT(PL)) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_cmd(req_cmd), .req_addr(req_addr), .req_len(req_len), .req_data(req_data),
    .req_err(req_err), .req_err_code(req_err_code), .busy(busy), .byte_cnt(byte_cnt),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data), .tx_go(tx_go),
    .ser_done(ser_done), .done_ack(done_ack)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic bit pl_cmd(input logic [3:0] c);
    return (c == 4'h8) || (c == 4'h0) || (c == 4'h4);
  endfunction

  function automatic int exp_total(input logic [3:0] c, input int len);
    return ((len == 0) ? 3 : 4) + (pl_cmd(c) ? len : 0);
  endfunction

  function automatic int exp_byte(input logic [3:0] c, input logic [19:0] a,
                                  input int len, input logic [127:0] d, input int i);
    if (i == 0) return {c, a[19:16]};
    if (i == 1) return a[15:8];
    if (i == 2) return a[7:0];
    if (i == 3 && len != 0) return len - 1;
    return d[(i - 4) * 8 +: 8];
  endfunction

  task automatic run_req(input logic [3:0] c, input logic [19:0] a, input int len,
                         input int rdy_pct, input int drop_d);
    int tot, got, ack_n, go_n, cyc, ack_cyc, last_hs, sd_rise, dcnt;
    bit fin, stall, tmo;
    logic [7:0] pdata;
    logic [127:0] d;
    d = {$urandom, $urandom, $urandom, $urandom};
    @(negedge clk);
    chk(req_ready == 1'b1, "R10 ready when idle", req_ready, 1);
    req_cmd = c; req_addr = a; req_len = 5'(len); req_data = d; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    req_data = '0;
    if (len > MAXL) begin
      chk(req_err == 1'b1 && req_err_code == 2'd1, "R9 length reject", req_err_code, 1);
      for (int k = 0; k < 4; k++) begin
        chk(!tx_valid && !done_ack && !busy && !tx_go, "R9 nothing started", busy, 0);
        @(negedge clk);
      end
      return;
    end
    tot = exp_total(c, len);
    tmo = (drop_d > PL);
    chk(int'(byte_cnt) == tot, "R3 byte count", byte_cnt, tot);
    got = 0; ack_n = 0; go_n = 0; cyc = 0; ack_cyc = 0; last_hs = -10;
    sd_rise = -1; dcnt = 0; fin = 0; stall = 0; pdata = '0;
    while (!fin && cyc < 400) begin
      if (done_ack) begin
        ack_n++;
        ack_cyc = cyc;
        chk(cyc == 0, "R7 ack one cycle after accept", cyc, 0);
        if (drop_d == 0) ser_done = 1'b0; else dcnt = drop_d;
      end else if (dcnt > 0) begin
        dcnt--;
        if (dcnt == 0) ser_done = 1'b0;
      end
      if (req_err) begin
        chk(tmo, "R8 unexpected error", 1, 0);
        chk(req_err_code == 2'd2, "R8 error code", req_err_code, 2);
        chk(cyc - ack_cyc == PL + 1, "R8 poll bound", cyc - ack_cyc, PL + 1);
        chk(got == 0, "R8 no bytes", got, 0);
        ser_done = 1'b1;
        dcnt = 0;
        fin = 1;
      end
      if (tx_valid) begin
        chk(ack_n == 1 && !ser_done, "R7 send only after done dropped", ser_done, 0);
        if (stall) chk(tx_data == pdata, "R5 byte held under stall", tx_data, pdata);
        chk(got < tot, "R5 extra byte", got, tot);
        tx_ready = (($urandom % 100) < rdy_pct);
        if (tx_ready) begin
          chk(int'(tx_data) == exp_byte(c, a, len, d, got),
              (got < 3) ? "R1 header byte" : ((got == 3 && len != 0) ? "R2 length byte" : "R4 payload byte"),
              tx_data, exp_byte(c, a, len, d, got));
          got++;
          if (got == tot) last_hs = cyc;
          stall = 0;
        end else begin
          stall = 1;
          pdata = tx_data;
        end
      end else begin
        tx_ready = 1'b0;
      end
      if (tx_go) begin
        go_n++;
        chk(cyc == last_hs + 1, "R6 go after last byte", cyc, last_hs + 1);
        chk(got == tot, "R5 bytes before go", got, tot);
        chk(go_n == 1, "R6 single go", go_n, 1);
        sd_rise = cyc + 1 + int'($urandom % 4);
      end
      if (go_n > 0 && sd_rise >= 0) begin
        if (cyc <= sd_rise) begin
          chk(busy && !req_ready, "R10 busy until done", busy, 1);
          if (cyc == sd_rise) ser_done = 1'b1;
        end else begin
          chk(!busy && req_ready, "R10 idle after done", busy, 0);
          fin = 1;
        end
      end
      cyc++;
      @(negedge clk);
    end
    tx_ready = 1'b0;
    chk(fin, "R10 request completes", 0, 1);
    if (!tmo) chk(go_n == 1 && ack_n == 1, "R6 one go per frame", go_n, 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    tests++;
    $display("FAIL watchdog: actual running expected finished");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready && !busy && !tx_valid && !tx_go && !done_ack && !req_err,
        "R11 reset state", busy, 0);
    run_req(4'h8, 20'hABCDE, 16, 100, 2);   // max native write
    run_req(4'h9, 20'h12345, 1, 50, 0);     // native read, one byte
    run_req(4'h9, 20'h00F0F, 0, 70, 3);     // length zero: three bytes
    run_req(4'h4, 20'hFFFFF, 0, 100, 1);    // I2C write MOT, no length byte
    run_req(4'h2, 20'h00050, 5, 60, 2);     // status request: no payload
    run_req(4'h6, 20'h00050, 9, 60, 2);     // status request MOT: no payload
    run_req(4'h0, 20'h00050, 3, 40, 4);     // I2C write, payload
    run_req(4'h8, 20'h11111, 17, 100, 0);   // one over the limit
    run_req(4'h1, 20'h22222, 31, 100, 0);   // far over the limit
    run_req(4'h8, 20'h33333, 2, 100, PL);   // done drops in last poll cycle
    run_req(4'h8, 20'h44444, 2, 100, PL + 1); // done stuck: timeout
    run_req(4'h9, 20'h55555, 4, 30, 1);     // recovers after timeout
    for (int n = 0; n < 40; n++) begin
      run_req(4'($urandom % 16), 20'($urandom), int'($urandom % 18),
              30 + int'($urandom % 71), int'($urandom % 8));
    end
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule